// File: doc/BRIEF.md
# Dual-Section Decade Counter

This block is a four-bit counter made of two sections that count independently. A two-state section advances on each falling edge of count input `cnt_a_i` and drives output bit 0. A five-state section advances on each falling edge of count input `cnt_b_i` and drives output bits 3..1. Both count inputs are sampled by the system clock. A falling edge is recognised when the sampled value goes from high to low between two clock edges, and it produces a one-cycle step enable. The counter is a synchronous model of a classic ripple counter.

Two pairs of control inputs act on both sections at once. When both pins of the clear pair are high, the outputs go to zero. When both pins of the preset pair are high, the outputs go to nine (binary 1001), which supports nine's-complement BCD use. The preset pair wins over the clear pair.

The sections are joined outside the block. If output bit 0 is wired back to `cnt_b_i` and pulses are applied to `cnt_a_i`, the block counts in BCD order. If output bit 3 is wired to `cnt_a_i` and pulses are applied to `cnt_b_i`, output bit 0 becomes a symmetric divide-by-ten square wave. The block has no streaming data path, so every pin is a plain level signal.

Top module: `decade_split_ctr`

## Requirements
- R1: While `rst_n` is low, the output `q_o` is 0000 and the sampled history of both count inputs is held at low. A count input that is still low on the first clock after reset therefore produces no step.
- R2: Each falling edge on `cnt_a_i` toggles `q_o[0]`. A rising edge on `cnt_a_i` leaves `q_o` unchanged.
- R3: Falling edges on `cnt_b_i` step the code `q_o[3:1]` (bit 1 is the LSB) through 0,1,2,3,4 and then back to 0. These steps leave `q_o[0]` unchanged.
- R4: A step becomes visible after the first clock edge at which the count input is sampled low, provided it was sampled high at the clock edge before.
- R5: A clock edge at which `clr_a_i` and `clr_b_i` are both high, and the preset pair is not both high, sets `q_o` to 0000. A clear pin that is high alone has no effect.
- R6: A clock edge at which `nine_a_i` and `nine_b_i` are both high sets `q_o` to 1001. A preset pin that is high alone has no effect.
- R7: When both pairs are active in the same cycle, the result is 1001.
- R8: When either pair is active, no counting takes place. A falling edge that arrives during that cycle is discarded and is not applied later.
- R9: With `q_o[0]` wired to `cnt_b_i` and pulses applied to `cnt_a_i`, `q_o` reads 1, 2, … 9 and then 0 after successive pulses.
- R10: With `q_o[3]` wired to `cnt_a_i` and pulses applied to `cnt_b_i`, starting from 0000, `q_o[0]` is low after pulses 1–4, high after pulses 5–9, and low again after pulse 10.
- R11: The code `q_o[3:1]` never holds a value above 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Active-low synchronous system reset |
| cnt_a_i | input | 1 | Count input of the two-state section |
| cnt_b_i | input | 1 | Count input of the five-state section |
| clr_a_i | input | 1 | Clear pair, first pin |
| clr_b_i | input | 1 | Clear pair, second pin |
| nine_a_i | input | 1 | Preset-to-nine pair, first pin |
| nine_b_i | input | 1 | Preset-to-nine pair, second pin |
| q_o | output | 4 | Count value: bit 0 from the two-state section, bits 3..1 from the five-state section |

## Verification
On every cycle the assertions check these properties:
- the clear, preset and priority results;
- that the output holds when no falling edge and no control is present;
- that bit 0 toggles on a falling edge of `cnt_a_i`;
- that the five-state code stays in range.

Only the bench scenarios can show the following:
- the exact order of the five-state sequence and its wrap;
- the one-edge latency;
- that an edge swallowed during a control cycle stays lost;
- the behaviour of the two external wirings, where a ripple from one section feeds the other. This covers the BCD sequence and the 5/5 duty of the divide-by-ten.

// File: rtl/decade_split_pkg.sv
package decade_split_pkg;
  typedef enum logic [1:0] {
    OP_COUNT = 2'd0,
    OP_CLEAR = 2'd1,
    OP_NINE  = 2'd2
  } ctl_op_t;
endpackage

// File: rtl/ctl_decode.sv
module ctl_decode
  import decade_split_pkg::*;
(
  input  logic    clr_a_i,
  input  logic    clr_b_i,
  input  logic    nine_a_i,
  input  logic    nine_b_i,
  output ctl_op_t op_o
);
  logic clr_hit, nine_hit;
  assign clr_hit  = clr_a_i & clr_b_i;
  assign nine_hit = nine_a_i & nine_b_i;

  always_comb begin
    if (nine_hit)      op_o = OP_NINE;
    else if (clr_hit)  op_o = OP_CLEAR;
    else               op_o = OP_COUNT;
  end
endmodule

// File: rtl/fall_detect.sv
module fall_detect #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] level_i,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] hist_q;

  for (genvar g = 0; g < N; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) hist_q[g] <= 1'b0;
      else        hist_q[g] <= level_i[g];
    end
    assign fall_o[g] = hist_q[g] & ~level_i[g];
  end
endmodule

// File: rtl/mod_stage.sv
module mod_stage
  import decade_split_pkg::*;
#(
  parameter int MOD    = 5,
  parameter int W      = (MOD > 2) ? $clog2(MOD) : 1,
  parameter int PRESET = MOD - 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ctl_op_t      op_i,
  input  logic         step_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);
  localparam logic [W-1:0] PSET = W'(PRESET);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    unique case (op_i)
      OP_NINE:  cnt_d = PSET;
      OP_CLEAR: cnt_d = '0;
      default: begin
        if (step_i) cnt_d = (cnt_q >= LAST) ? '0 : cnt_q + W'(1);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/decade_split_ctr.sv
module decade_split_ctr
  import decade_split_pkg::*;
#(
  parameter int HI_MOD = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cnt_a_i,
  input  logic                   cnt_b_i,
  input  logic                   clr_a_i,
  input  logic                   clr_b_i,
  input  logic                   nine_a_i,
  input  logic                   nine_b_i,
  output logic [$clog2(HI_MOD):0] q_o
);
  localparam int HI_W = $clog2(HI_MOD);

  ctl_op_t    op;
  logic [1:0] fall;
  logic [0:0] lo_cnt;
  logic [HI_W-1:0] hi_cnt;

  ctl_decode u_ctl (
    .clr_a_i (clr_a_i),
    .clr_b_i (clr_b_i),
    .nine_a_i(nine_a_i),
    .nine_b_i(nine_b_i),
    .op_o    (op)
  );

  fall_detect #(.N(2)) u_fall (
    .clk    (clk),
    .rst_n  (rst_n),
    .level_i({cnt_b_i, cnt_a_i}),
    .fall_o (fall)
  );

  mod_stage #(.MOD(2), .W(1), .PRESET(1)) u_lo (
    .clk   (clk),
    .rst_n (rst_n),
    .op_i  (op),
    .step_i(fall[0]),
    .cnt_o (lo_cnt)
  );

  mod_stage #(.MOD(HI_MOD), .W(HI_W), .PRESET(HI_MOD - 1)) u_hi (
    .clk   (clk),
    .rst_n (rst_n),
    .op_i  (op),
    .step_i(fall[1]),
    .cnt_o (hi_cnt)
  );

  assign q_o = {hi_cnt, lo_cnt};
endmodule

// File: rtl/decade_split_ctr_chk.sv
module decade_split_ctr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cnt_a_i,
  input logic       cnt_b_i,
  input logic       clr_a_i,
  input logic       clr_b_i,
  input logic       nine_a_i,
  input logic       nine_b_i,
  input logic [3:0] q_o
);
  logic ctl_on;
  assign ctl_on = (clr_a_i & clr_b_i) | (nine_a_i & nine_b_i);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_a_i && clr_b_i && !(nine_a_i && nine_b_i)) |=> (q_o == 4'b0000));

  p_nine_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (nine_a_i && nine_b_i) |=> (q_o == 4'b1001));

  p_nine_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (nine_a_i && nine_b_i && clr_a_i && clr_b_i) |=> (q_o == 4'b1001));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_on && !($past(cnt_a_i) && !cnt_a_i) && !($past(cnt_b_i) && !cnt_b_i))
      |=> $stable(q_o));

  p_lo_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_on && $past(cnt_a_i) && !cnt_a_i) |=> (q_o[0] != $past(q_o[0])));

  p_hi_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    q_o[3:1] <= 3'd4);
endmodule

bind decade_split_ctr decade_split_ctr_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cnt_a_i (cnt_a_i),
  .cnt_b_i (cnt_b_i),
  .clr_a_i (clr_a_i),
  .clr_b_i (clr_b_i),
  .nine_a_i(nine_a_i),
  .nine_b_i(nine_b_i),
  .q_o     (q_o)
);

// File: tb/decade_split_ctr_bench.sv
module decade_split_ctr_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_reg = 1'b0, b_reg = 1'b0;
  logic clr_a = 1'b0, clr_b = 1'b0, nine_a = 1'b0, nine_b = 1'b0;
  logic [1:0] mode = 2'd0;
  logic a_drv, b_drv;
  logic [3:0] q;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  assign a_drv = (mode == 2'd2) ? q[3] : a_reg;
  assign b_drv = (mode == 2'd1) ? q[0] : b_reg;

  decade_split_ctr u_decade_split_ctr (
    .clk(clk), .rst_n(rst_n), .cnt_a_i(a_drv), .cnt_b_i(b_drv),
    .clr_a_i(clr_a), .clr_b_i(clr_b), .nine_a_i(nine_a), .nine_b_i(nine_b),
    .q_o(q)
  );

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_a();
    a_reg = 1'b1; tick(3); a_reg = 1'b0; tick(3);
  endtask

  task automatic pulse_b();
    b_reg = 1'b1; tick(3); b_reg = 1'b0; tick(3);
  endtask

  task automatic zero_out();
    clr_a = 1'b1; clr_b = 1'b1; tick(1); clr_a = 1'b0; clr_b = 1'b0;
  endtask

  task automatic t_reset();
    a_reg = 1'b0; b_reg = 1'b0; rst_n = 1'b0; tick(3);
    check(q, 4'b0000, "R1 reset value");
    rst_n = 1'b1; tick(3);
    check(q, 4'b0000, "R1 low input after reset gives no step");
  endtask

  task automatic t_low();
    a_reg = 1'b1; tick(3);
    check(q, 4'b0000, "R2 rising edge ignored");
    a_reg = 1'b0;
    check(q, 4'b0000, "R4 no change before sampling edge");
    tick(1);
    check(q, 4'b0001, "R4 step after first low sample");
    pulse_a();
    check(q, 4'b0000, "R2 second toggle");
  endtask

  task automatic t_high();
    logic [3:0] exp_seq [6] = '{4'd2, 4'd4, 4'd6, 4'd8, 4'd0, 4'd2};
    for (int i = 0; i < 6; i++) begin
      pulse_b();
      check(q, exp_seq[i], "R3 five-state sequence");
    end
    pulse_a();
    check(q, 4'b0011, "R3 low bit independent");
  endtask

  task automatic t_clear();
    clr_a = 1'b1; tick(2);
    check(q, 4'b0011, "R5 single clear pin ignored");
    clr_a = 1'b0; clr_b = 1'b1; tick(2);
    check(q, 4'b0011, "R5 other clear pin ignored");
    clr_a = 1'b1; tick(1);
    check(q, 4'b0000, "R5 both clear pins");
    clr_a = 1'b0; clr_b = 1'b0; tick(1);
  endtask

  task automatic t_nine();
    nine_b = 1'b1; tick(2);
    check(q, 4'b0000, "R6 single preset pin ignored");
    nine_a = 1'b1; tick(1);
    check(q, 4'b1001, "R6 preset to nine");
    nine_a = 1'b0; nine_b = 1'b0; zero_out(); tick(1);
    clr_a = 1'b1; clr_b = 1'b1; nine_a = 1'b1; nine_b = 1'b1; tick(1);
    check(q, 4'b1001, "R7 preset beats clear");
    nine_a = 1'b0; nine_b = 1'b0; tick(1);
    check(q, 4'b0000, "R5 clear after preset released");
  endtask

  task automatic t_hold();
    a_reg = 1'b1; b_reg = 1'b1; tick(3);
    a_reg = 1'b0; b_reg = 1'b0; tick(2);
    check(q, 4'b0000, "R8 edges during clear discarded");
    clr_a = 1'b0; clr_b = 1'b0; tick(3);
    check(q, 4'b0000, "R8 discarded edge not applied later");
  endtask

  task automatic t_bcd();
    zero_out(); tick(1);
    mode = 2'd1;
    for (int n = 1; n <= 10; n++) begin
      pulse_a();
      check(q, 4'((n) % 10), "R9 BCD order");
      checks++;
      if (q[3:1] > 3'd4) begin
        errors++;
        $display("FAIL R11: actual %0d expected <= 4", q[3:1]);
      end
    end
    mode = 2'd0; tick(1);
  endtask

  task automatic t_sym();
    zero_out(); tick(1);
    mode = 2'd2;
    for (int n = 1; n <= 10; n++) begin
      pulse_b();
      check({3'b000, q[0]}, (n >= 5 && n <= 9) ? 4'd1 : 4'd0, "R10 divide-by-ten duty");
    end
    mode = 2'd0; tick(1);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(1);
    t_reset();
    t_low();
    t_high();
    t_clear();
    t_nine();
    clr_a = 1'b1; clr_b = 1'b1;
    t_hold();
    t_bcd();
    t_sym();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule